// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit registers that a small SoC maps into its control space. Software reaches it over a plain word-oriented register bus that carries a byte address, a write strobe with write data, and a read strobe with registered read data. Most words are general storage. At reset, four words near the start of the bank load fixed identification and revision values.

One offset in the bank also acts as a system control port. Writing certain codes to it still stores the word, and it also sends a one-cycle request for a system reset or for a shutdown to the power and reset logic outside this block. Three status offsets always read back with bits 29 and 28 set. The stored word stays as written, so the same storage read through its mirror shows the raw value.

The window is 4 KB and the bank holds 512 words. The upper 2 KB of the window mirrors the lower 2 KB. Request decoding and read forcing look at the exact offset inside the window, so the mirrors of those offsets behave as plain storage.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, word index 0x40 holds 0x05F20121, 0x41 holds 0x00000002, 0x42 holds 0x05F30121, 0x43 holds 0x05F40121, and every other word holds zero. Both request outputs are low.
- R2: A write inside the window stores the write data at word index (byte offset / 4) modulo 512. Address bits [1:0] are ignored.
- R3: A write to byte offset 0xF00 with data 1 or 2 sets the reset request high for exactly the one cycle after the write is accepted.
- R4: A write to byte offset 0xF00 with data 3 sets the shutdown request high for the one cycle after the write. Any other data raises no request. The two requests are never high together.
- R5: A read at byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000. The stored word itself is not changed. A read at 0x104 is not forced.
- R6: Read data is registered. It is valid in the cycle after the read strobe and holds its value while no read is issued. A read in the same cycle as a write to the same word returns the old contents.
- R7: An address of 0x1000 or above is outside the window. Reading it returns zero, and writing it changes no word and raises no request.
- R8: Byte offsets N and N + 0x800 reach the same word. Forcing and request decoding apply only at the exact offsets named in R3 to R5, so offsets 0x700, 0x900, 0x908 and 0x90C act as plain storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 16 | Byte address |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_data | output | 32 | Registered read data |
| sys_reset_req | output | 1 | One-cycle system reset request |
| sys_shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The control offset is written with each code from 0 through 4. This separates the two reset codes from the shutdown code and from codes that must stay silent, and each word is read back through its mirror to show that storing and requesting are independent. The status offsets are read both at reset and after fresh writes, and each is compared with its unforced mirror, which shows that the forcing is applied on the read path only. Further patterns cover a misaligned address, a read and a write to the same word in one cycle, addresses above the window, and a write to the mirror of the control offset.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  // Byte offsets with special behaviour inside the window
  localparam int unsigned CtrlOffset   = 'hF00;
  localparam int unsigned StatOffsetA  = 'h100;
  localparam int unsigned StatOffsetB  = 'h108;
  localparam int unsigned StatOffsetC  = 'h10C;
  localparam logic [31:0] StatForceMsk = 32'h3000_0000;

  // Codes written to the control offset
  localparam int unsigned CodeResetA   = 1;
  localparam int unsigned CodeResetB   = 2;
  localparam int unsigned CodeShutdown = 3;

  // Reset contents of one storage word
  function automatic logic [31:0] reset_word(int unsigned idx);
    case (idx)
      'h40:    reset_word = 32'h05F2_0121;
      'h41:    reset_word = 32'h0000_0002;
      'h42:    reset_word = 32'h05F3_0121;
      'h43:    reset_word = 32'h05F4_0121;
      default: reset_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_store.sv
module sysctl_store #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 512,
  localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem_q [NUM_WORDS];
  logic [DATA_W-1:0] mem_d [NUM_WORDS];

  always_comb begin
    mem_d = mem_q;
    if (wr_en) begin
      mem_d[wr_idx] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) begin
        mem_q[i] <= DATA_W'(sysctl_pkg::reset_word(i));
      end
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  assign rd_word = mem_q[rd_idx];
endmodule

// File: rtl/sysctl_req_decode.sv
module sysctl_req_decode #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WOFF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              in_win,
  input  logic [WOFF_W-1:0] word_off,
  input  logic [DATA_W-1:0] wr_data,
  output logic              reset_req,
  output logic              shutdown_req
);
  import sysctl_pkg::*;

  localparam logic [WOFF_W-1:0] CtrlWord = WOFF_W'(CtrlOffset >> 2);

  logic ctrl_hit;
  logic reset_d, shutdown_d;
  logic reset_q, shutdown_q;

  always_comb begin
    ctrl_hit   = wr_en && in_win && (word_off == CtrlWord);
    reset_d    = ctrl_hit && ((wr_data == DATA_W'(CodeResetA)) ||
                              (wr_data == DATA_W'(CodeResetB)));
    shutdown_d = ctrl_hit && (wr_data == DATA_W'(CodeShutdown));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_q    <= 1'b0;
      shutdown_q <= 1'b0;
    end else begin
      reset_q    <= reset_d;
      shutdown_q <= shutdown_d;
    end
  end

  assign reset_req    = reset_q;
  assign shutdown_req = shutdown_q;
endmodule

// File: rtl/sysctl_rd_path.sv
module sysctl_rd_path #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WOFF_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              in_win,
  input  logic [WOFF_W-1:0] word_off,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rd_data
);
  import sysctl_pkg::*;

  localparam logic [WOFF_W-1:0] StatWordA = WOFF_W'(StatOffsetA >> 2);
  localparam logic [WOFF_W-1:0] StatWordB = WOFF_W'(StatOffsetB >> 2);
  localparam logic [WOFF_W-1:0] StatWordC = WOFF_W'(StatOffsetC >> 2);

  logic              force_hit;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    force_hit = (word_off == StatWordA) || (word_off == StatWordB) ||
                (word_off == StatWordC);
    if (!in_win) begin
      rd_d = '0;
    end else if (force_hit) begin
      rd_d = word | DATA_W'(StatForceMsk);
    end else begin
      rd_d = word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 512,
  parameter int unsigned WIN_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic              reg_rd_en,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              sys_reset_req,
  output logic              sys_shutdown_req
);
  localparam int unsigned OFF_W  = $clog2(WIN_BYTES);
  localparam int unsigned WOFF_W = OFF_W - 2;
  localparam int unsigned IDX_W  = $clog2(NUM_WORDS);

  logic              in_win;
  logic [WOFF_W-1:0] word_off;
  logic [IDX_W-1:0]  word_idx;
  logic [DATA_W-1:0] cur_word;
  logic              store_we;
  logic              unused_lsb;

  assign in_win     = (reg_addr[ADDR_W-1:OFF_W] == '0);
  assign word_off   = reg_addr[OFF_W-1:2];
  assign word_idx   = word_off[IDX_W-1:0];
  assign store_we   = reg_wr_en && in_win;
  assign unused_lsb = ^reg_addr[1:0];

  sysctl_store #(
    .DATA_W   (DATA_W),
    .NUM_WORDS(NUM_WORDS)
  ) store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (store_we),
    .wr_idx (word_idx),
    .wr_data(reg_wr_data),
    .rd_idx (word_idx),
    .rd_word(cur_word)
  );

  sysctl_req_decode #(
    .DATA_W(DATA_W),
    .WOFF_W(WOFF_W)
  ) req_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr_en),
    .in_win      (in_win),
    .word_off    (word_off),
    .wr_data     (reg_wr_data),
    .reset_req   (sys_reset_req),
    .shutdown_req(sys_shutdown_req)
  );

  sysctl_rd_path #(
    .DATA_W(DATA_W),
    .WOFF_W(WOFF_W)
  ) rd_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (reg_rd_en),
    .in_win  (in_win),
    .word_off(word_off),
    .word    (cur_word),
    .rd_data (reg_rd_data)
  );
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_wr_data,
  input logic              reg_rd_en,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic              sys_reset_req,
  input logic              sys_shutdown_req
);
  localparam logic [ADDR_W-1:0] CtrlAddr = ADDR_W'('hF00);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_reset_req && sys_shutdown_req)); // R4

  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> ($past(reg_wr_en) &&
                       ($past(reg_addr[ADDR_W-1:2]) == CtrlAddr[ADDR_W-1:2]) &&
                       (($past(reg_wr_data) == DATA_W'(1)) ||
                        ($past(reg_wr_data) == DATA_W'(2))))); // R3

  AST_SHUTDOWN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sys_shutdown_req |-> ($past(reg_wr_en) &&
                          ($past(reg_addr[ADDR_W-1:2]) == CtrlAddr[ADDR_W-1:2]) &&
                          ($past(reg_wr_data) == DATA_W'(3)))); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_rd_en) |-> $stable(reg_rd_data)); // R6

  AST_OUT_OF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd_en) && ($past(reg_addr) >= ADDR_W'('h1000))) |->
      (reg_rd_data == '0)); // R7

  AST_STATUS_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rd_en) && (($past(reg_addr[ADDR_W-1:2]) == ADDR_W'('h100) >> 2) ||
                          ($past(reg_addr[ADDR_W-1:2]) == ADDR_W'('h108) >> 2) ||
                          ($past(reg_addr[ADDR_W-1:2]) == ADDR_W'('h10C) >> 2))) |->
      (reg_rd_data[29:28] == 2'b11)); // R5
endmodule

bind sysctl_regfile sysctl_regfile_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .reg_addr        (reg_addr),
  .reg_wr_en       (reg_wr_en),
  .reg_wr_data     (reg_wr_data),
  .reg_rd_en       (reg_rd_en),
  .reg_rd_data     (reg_rd_data),
  .sys_reset_req   (sys_reset_req),
  .sys_shutdown_req(sys_shutdown_req)
);

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
module sysctl_regfile_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] reg_addr;
  logic        reg_wr_en;
  logic [31:0] reg_wr_data;
  logic        reg_rd_en;
  logic [31:0] reg_rd_data;
  logic        sys_reset_req;
  logic        sys_shutdown_req;

  int n_checks = 0;
  int n_fails  = 0;

  sysctl_regfile dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_addr        (reg_addr),
    .reg_wr_en       (reg_wr_en),
    .reg_wr_data     (reg_wr_data),
    .reg_rd_en       (reg_rd_en),
    .reg_rd_data     (reg_rd_data),
    .sys_reset_req   (sys_reset_req),
    .sys_shutdown_req(sys_shutdown_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic bus_write(logic [15:0] a, logic [31:0] d);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  task automatic t_reset_defaults();
    logic [31:0] v;
    check("R1 reset_req idle", {31'b0, sys_reset_req}, 32'h0);
    check("R1 shutdown_req idle", {31'b0, sys_shutdown_req}, 32'h0);
    bus_read(16'h0900, v); check("R1 word 0x40 via mirror", v, 32'h05F2_0121);
    bus_read(16'h0104, v); check("R1 word 0x41", v, 32'h0000_0002);
    bus_read(16'h0908, v); check("R1 word 0x42 via mirror", v, 32'h05F3_0121);
    bus_read(16'h090C, v); check("R1 word 0x43 via mirror", v, 32'h05F4_0121);
    bus_read(16'h0000, v); check("R1 word 0 zero", v, 32'h0);
    bus_read(16'h0F00, v); check("R1 control word zero", v, 32'h0);
  endtask

  task automatic t_status_forcing();
    logic [31:0] v;
    bus_read(16'h0100, v); check("R5 forced 0x100 at reset", v, 32'h35F2_0121);
    bus_read(16'h0108, v); check("R5 forced 0x108 at reset", v, 32'h35F3_0121);
    bus_read(16'h010C, v); check("R5 forced 0x10C at reset", v, 32'h35F4_0121);
    bus_write(16'h0108, 32'h0000_0055);
    bus_read(16'h0108, v); check("R5 forced after write", v, 32'h3000_0055);
    bus_read(16'h0908, v); check("R5 R8 stored word unchanged", v, 32'h0000_0055);
    bus_write(16'h0104, 32'h1234_5678);
    bus_read(16'h0104, v); check("R5 0x104 not forced", v, 32'h1234_5678);
  endtask

  task automatic t_control_codes();
    logic [31:0] v;
    for (int code = 0; code <= 4; code++) begin
      bus_write(16'h0F00, 32'(code));
      check($sformatf("R3 reset pulse code %0d", code), {31'b0, sys_reset_req},
            32'((code == 1) || (code == 2)));
      check($sformatf("R4 shutdown pulse code %0d", code), {31'b0, sys_shutdown_req},
            32'(code == 3));
      @(negedge clk);
      check($sformatf("R3 R4 pulses end code %0d", code),
            {30'b0, sys_reset_req, sys_shutdown_req}, 32'h0);
      bus_read(16'h0700, v); check($sformatf("R2 R8 code %0d stored", code), v, 32'(code));
    end
    bus_write(16'h0700, 32'h1);
    check("R8 mirror of control offset silent",
          {30'b0, sys_reset_req, sys_shutdown_req}, 32'h0);
    bus_write(16'h1F00, 32'h3);
    check("R7 out of window control silent",
          {30'b0, sys_reset_req, sys_shutdown_req}, 32'h0);
    bus_read(16'h0F00, v); check("R7 out of window write dropped", v, 32'h1);
  endtask

  task automatic t_addressing();
    logic [31:0] v;
    bus_write(16'h0203, 32'hCAFE_0001);
    bus_read(16'h0200, v); check("R2 low address bits ignored", v, 32'hCAFE_0001);
    bus_read(16'h0A01, v); check("R8 mirror read of 0x200", v, 32'hCAFE_0001);
    bus_write(16'h1000, 32'hDEAD_BEEF);
    bus_read(16'h0000, v); check("R7 write above window dropped", v, 32'h0);
    bus_read(16'h1000, v); check("R7 read above window zero", v, 32'h0);
    bus_read(16'hF104, v); check("R7 far read zero", v, 32'h0);
  endtask

  task automatic t_read_timing();
    logic [31:0] v;
    bus_write(16'h0300, 32'hAAAA_0000);
    reg_addr = 16'h0300; reg_wr_data = 32'hBBBB_1111;
    reg_wr_en = 1'b1; reg_rd_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_rd_en = 1'b0;
    check("R6 read with write returns old", reg_rd_data, 32'hAAAA_0000);
    bus_read(16'h0300, v); check("R6 new value after write", v, 32'hBBBB_1111);
    reg_addr = 16'h0104;
    @(negedge clk);
    @(negedge clk);
    check("R6 read data holds without strobe", reg_rd_data, 32'hBBBB_1111);
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0; reg_rd_en = 1'b0;
    repeat (4) @(negedge clk);
    check("R6 read data zero in reset", reg_rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_defaults();
    t_status_forcing();
    t_control_codes();
    t_addressing();
    t_read_timing();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule